// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scanner with Key Matrix

This block drives a multiplexed vacuum fluorescent display from a display memory of twelve 24-bit words, one word per digit. Time is divided into slots of 16 ticks. The block steps through the active digit slots. In each slot it enables one grid and presents that digit's word on the segment lines. A dimming setting shortens the lit part of every slot.

After the last digit, one key-scan slot follows. In that slot all grids are off and the 16 low segment lines act as key sources, raised one at a time. Two key return inputs are sensed for each source. The 32 results are published to a key memory when the slot ends.

Eight outputs are shared. Depending on the digit count they carry either the high segments or the extra grids, in reverse order. The digit count selects between 16 segments by 12 digits and 24 segments by 4 digits. It is picked up only at the boundary of a display cycle, so a frame is never shown half in one mode and half in another.

Top module: `vfd_scan`

## Requirements
- R1: Reset places the block at tick 0 of a key-scan slot with a key memory of zero and a latched digit count of 12. Every slot lasts 16 ticks. A display cycle is digit slots 0 to D−1 followed by one key-scan slot.
- R2: `mode_i` value m in 0..8 selects D = m+4 active digits. Any value above 8 selects D = 12. The segment count is then 28−D.
- R3: Dedicated grid output `grid_o[g]` (g = 0..3) is lit only during digit slot g. Shared output `sgrid_o[j]` (j = 0..7, segment 17+j) acts as a grid when D > 11−j and is then lit only during digit slot 11−j.
- R4: In digit slot s, bit b of memory word s drives `seg_o[b]` for b < 16. Bit 16+j drives `sgrid_o[j]` when that output is a segment.
- R5: With dimming value d (0..7), grids and segments in a digit slot are lit only during ticks 0 to 2d of the slot and are low for the rest of it.
- R6: With `disp_on_i` low, all grid and segment outputs stay low in digit slots. Key scanning and the key memory keep running.
- R7: In the key-scan slot at tick t, `seg_o` equals 1<<t and all `grid_o` and `sgrid_o` outputs are low.
- R8: `key_mem_o[t]` holds `key_a_i` and `key_mem_o[16+t]` holds `key_b_i`, both as sensed at key-scan tick t. The key memory changes only on the last tick of a key-scan slot.
- R9: A new `mode_i` value takes effect only at the end of a key-scan slot. The cycle in progress completes with the previous digit count.
- R10: `mem_addr_o` names the word of the next digit slot: s+1 during digit slot s when s < D−1, and 0 otherwise. The word on `mem_rdata_i` is taken on the slot's final tick.
- R11: While `tick_i` is low the block's state, and so every output, holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan time base enable, one tick per high cycle |
| mode_i | input | 4 | Digit count select (0..8 means 4..12 digits) |
| dim_i | input | 3 | Dimming step, 7 is brightest |
| disp_on_i | input | 1 | Display enable |
| mem_rdata_i | input | 24 | Display memory word at `mem_addr_o` |
| key_a_i | input | 1 | First key return line |
| key_b_i | input | 1 | Second key return line |
| seg_o | output | 16 | Segment lines 1..16, key sources during key scan |
| sgrid_o | output | 8 | Shared lines: segment 17+j or grid 12−j |
| grid_o | output | 4 | Dedicated grid lines 1..4 |
| mem_addr_o | output | 4 | Display memory read address |
| key_mem_o | output | 32 | Key memory, first return in bits 0..15 |

## Verification
The bench builds the block with its default geometry: 16 low segments, 8 shared lines, 4 dedicated grids and a 3-bit dimming step. With that geometry every digit count from 4 to 12, plus an out-of-range mode value, can be run for whole display cycles within a short run, and every dimming step can be swept. The bench compares each output on every clock against an arithmetic model driven by a computed memory pattern and a key matrix built from masks. This covers the point where each shared line switches between segment and grid, the cycle boundary for mode changes, display-off operation and held ticks.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
    localparam int SEG_LO   = 16;               // low segment / key-source lines
    localparam int SHARED   = 8;                // segment-or-grid lines
    localparam int GRID_FIX = 4;                // always-grid lines
    localparam int MAX_DIG  = GRID_FIX + SHARED;
    localparam int WORD_W   = SEG_LO + SHARED;
    localparam int CNT_W    = $clog2(SEG_LO);   // slot length equals key-source count
    localparam int DIG_W    = $clog2(MAX_DIG + 1);
    localparam int DIM_W    = 3;
    localparam int MODE_W   = 4;
    localparam int KMEM_W   = 2 * SEG_LO;

    typedef struct packed {
        logic             key;    // key-scan slot in progress
        logic [DIG_W-1:0] digit;  // current digit slot
        logic [DIG_W-1:0] ndig;   // digit count of this display cycle
        logic [CNT_W-1:0] cnt;    // tick within slot
    } seq_t;
endpackage

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
    import vfd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [MODE_W-1:0] mode_i,
    output seq_t              seq_o,
    output logic              load_o,
    output logic [DIG_W-1:0]  addr_o
);
    seq_t seq_d, seq_q;
    logic last_tick, last_dig;
    logic [DIG_W-1:0] mode_dig;

    always_comb begin
        if (mode_i > MODE_W'(SHARED)) mode_dig = DIG_W'(MAX_DIG);
        else                          mode_dig = DIG_W'(mode_i) + DIG_W'(GRID_FIX);
        last_tick = (seq_q.cnt == CNT_W'(SEG_LO - 1));
        last_dig  = (seq_q.digit == seq_q.ndig - DIG_W'(1));
        seq_d = seq_q;
        if (tick_i) begin
            seq_d.cnt = last_tick ? '0 : seq_q.cnt + CNT_W'(1);
            if (last_tick) begin
                if (seq_q.key) begin
                    seq_d.key   = 1'b0;
                    seq_d.digit = '0;
                    seq_d.ndig  = mode_dig;
                end else if (last_dig) begin
                    seq_d.key   = 1'b1;
                    seq_d.digit = '0;
                end else begin
                    seq_d.digit = seq_q.digit + DIG_W'(1);
                end
            end
        end
    end

    assign load_o = tick_i && last_tick && (seq_q.key || !last_dig);
    assign addr_o = (seq_q.key || last_dig) ? '0 : seq_q.digit + DIG_W'(1);
    assign seq_o  = seq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{key: 1'b1, digit: '0, ndig: DIG_W'(MAX_DIG), cnt: '0};
        else        seq_q <= seq_d;
    end

    // digit count only moves when a key-scan slot closes
    assert_mode_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_q.ndig) |-> $fell(seq_q.key));
    // digit index never reaches the latched count
    assert_digit_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.key |-> (seq_q.digit < seq_q.ndig));
    // held tick freezes the sequence
    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(seq_q));
endmodule

// File: rtl/vfd_scan_keys.sv
module vfd_scan_keys
    import vfd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              key_slot_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              key_a_i,
    input  logic              key_b_i,
    output logic [KMEM_W-1:0] kmem_o
);
    typedef struct packed {
        logic [KMEM_W-1:0] shadow;
        logic [KMEM_W-1:0] kmem;
    } kst_t;

    kst_t st_d, st_q;
    logic last_tick;

    always_comb begin
        last_tick = (cnt_i == CNT_W'(SEG_LO - 1));
        st_d = st_q;
        if (tick_i && key_slot_i) begin
            st_d.shadow[cnt_i]                = key_a_i;
            st_d.shadow[SEG_LO + int'(cnt_i)] = key_b_i;
            if (last_tick) st_d.kmem = st_d.shadow;
        end
    end

    assign kmem_o = st_q.kmem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // published key memory moves only at the close of a key-scan slot
    assert_kmem_update_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.kmem) |-> $past(tick_i && key_slot_i && last_tick));
endmodule

// File: rtl/vfd_scan_drive.sv
module vfd_scan_drive
    import vfd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  seq_t              seq_i,
    input  logic [DIM_W-1:0]  dim_i,
    input  logic              disp_on_i,
    output logic [SEG_LO-1:0] seg_o,
    output logic [SHARED-1:0] sgrid_o,
    output logic [GRID_FIX-1:0] grid_o
);
    logic [WORD_W-1:0] lat_d, lat_q;
    logic lit_win, active;

    always_comb begin
        lat_d   = load_i ? word_i : lat_q;
        lit_win = (seq_i.cnt < {dim_i, 1'b1});
        active  = disp_on_i && !seq_i.key && lit_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign seg_o = seq_i.key ? (SEG_LO'(1) << seq_i.cnt)
                             : (active ? lat_q[SEG_LO-1:0] : '0);

    for (genvar j = 0; j < SHARED; j++) begin : g_shared
        localparam int GRID_IDX = MAX_DIG - 1 - j;
        assign sgrid_o[j] = (seq_i.ndig > DIG_W'(GRID_IDX))
                          ? (active && (seq_i.digit == DIG_W'(GRID_IDX)))
                          : (active && lat_q[SEG_LO + j]);
    end

    for (genvar g = 0; g < GRID_FIX; g++) begin : g_grid
        assign grid_o[g] = active && (seq_i.digit == DIG_W'(g));
    end

    assert_fixed_grid_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_i.key && seq_i.digit >= DIG_W'(GRID_FIX)) |-> (grid_o == '0));
    assert_keyslot_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_i.key |-> (grid_o == '0 && sgrid_o == '0 && $countones(seg_o) == 1));
    assert_display_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_on_i && !seq_i.key) |-> (seg_o == '0 && sgrid_o == '0 && grid_o == '0));
    assert_dim_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_i.key && seq_i.cnt >= {dim_i, 1'b1}) |-> (seg_o == '0 && sgrid_o == '0 && grid_o == '0));
endmodule

// File: rtl/vfd_scan.sv
module vfd_scan
    import vfd_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [DIM_W-1:0]   dim_i,
    input  logic               disp_on_i,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    input  logic               key_a_i,
    input  logic               key_b_i,
    output logic [SEG_LO-1:0]  seg_o,
    output logic [SHARED-1:0]  sgrid_o,
    output logic [GRID_FIX-1:0] grid_o,
    output logic [DIG_W-1:0]   mem_addr_o,
    output logic [KMEM_W-1:0]  key_mem_o
);
    seq_t seq;
    logic load;

    vfd_scan_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .mode_i (mode_i),
        .seq_o  (seq),
        .load_o (load),
        .addr_o (mem_addr_o)
    );

    vfd_scan_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .word_i    (mem_rdata_i),
        .seq_i     (seq),
        .dim_i     (dim_i),
        .disp_on_i (disp_on_i),
        .seg_o     (seg_o),
        .sgrid_o   (sgrid_o),
        .grid_o    (grid_o)
    );

    vfd_scan_keys u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .key_slot_i (seq.key),
        .cnt_i      (seq.cnt),
        .key_a_i    (key_a_i),
        .key_b_i    (key_b_i),
        .kmem_o     (key_mem_o)
    );
endmodule

// File: tb/vfd_scan_bench.sv
module vfd_scan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic [3:0]  mode_i = 4'd8;
    logic [2:0]  dim_i = 3'd7;
    logic        disp_on_i = 1'b1;
    logic [23:0] mem_rdata_i;
    logic        key_a_i, key_b_i;
    logic [15:0] seg_o;
    logic [7:0]  sgrid_o;
    logic [3:0]  grid_o;
    logic [3:0]  mem_addr_o;
    logic [31:0] key_mem_o;

    logic [15:0] mask_a = 16'h0000, mask_b = 16'h0000;

    int checks = 0, errors = 0;
    bit done = 0;
    string phase = "R1";

    // model state
    bit m_key; int m_dig, m_cnt, m_nd;
    logic [15:0] m_sa, m_sb;
    logic [31:0] m_kmem;

    always #2 clk = ~clk;

    function automatic logic [23:0] pat(input int a);
        logic [3:0] a4 = 4'(a);
        return 24'hC35A96 ^ {6{a4}};
    endfunction

    function automatic int dmode(input logic [3:0] m);
        return (m > 4'd8) ? 12 : int'(m) + 4;
    endfunction

    assign mem_rdata_i = pat(int'(mem_addr_o));
    assign key_a_i = |(seg_o & mask_a);
    assign key_b_i = |(seg_o & mask_b);

    vfd_scan u_vfd_scan (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i), .dim_i(dim_i),
        .disp_on_i(disp_on_i), .mem_rdata_i(mem_rdata_i), .key_a_i(key_a_i),
        .key_b_i(key_b_i), .seg_o(seg_o), .sgrid_o(sgrid_o), .grid_o(grid_o),
        .mem_addr_o(mem_addr_o), .key_mem_o(key_mem_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s/%s: actual %h expected %h (key=%0d dig=%0d cnt=%0d D=%0d)",
                     tag, phase, got, exp, m_key, m_dig, m_cnt, m_nd);
        end
    endtask

    task automatic model_reset();
        m_key = 1; m_dig = 0; m_cnt = 0; m_nd = 12; m_sa = '0; m_sb = '0; m_kmem = '0;
    endtask

    task automatic model_advance();
        if (!rst_n || !tick_i) return;
        if (m_key) begin
            m_sa[m_cnt] = mask_a[m_cnt];
            m_sb[m_cnt] = mask_b[m_cnt];
        end
        if (m_cnt == 15) begin
            if (m_key) begin
                m_kmem = {m_sb, m_sa}; m_key = 0; m_dig = 0; m_nd = dmode(mode_i);
            end else if (m_dig == m_nd - 1) begin
                m_key = 1; m_dig = 0;
            end else m_dig++;
        end
        m_cnt = (m_cnt + 1) % 16;
    endtask

    task automatic check_all();
        bit act;
        logic [15:0] e_seg; logic [7:0] e_sh; logic [3:0] e_gr; int e_addr;
        logic [23:0] w;
        w = pat(m_dig);
        act = disp_on_i && !m_key && (m_cnt < 2 * int'(dim_i) + 1);
        e_seg = m_key ? (16'd1 << m_cnt) : (act ? w[15:0] : 16'h0);
        for (int j = 0; j < 8; j++)
            e_sh[j] = (m_nd > 11 - j) ? (act && m_dig == 11 - j) : (act && w[16 + j]);
        for (int g = 0; g < 4; g++) e_gr[g] = act && (m_dig == g);
        e_addr = (m_key || m_dig == m_nd - 1) ? 0 : m_dig + 1;
        chk(m_key ? "R7" : (!disp_on_i ? "R6" : "R4"), 32'(seg_o), 32'(e_seg));
        chk(m_key ? "R7" : "R3", 32'(sgrid_o), 32'(e_sh));
        chk("R3", 32'(grid_o), 32'(e_gr));
        chk("R10", 32'(mem_addr_o), 32'(e_addr));
        chk("R8", key_mem_o, m_kmem);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            model_advance();
            @(posedge clk);
            @(negedge clk);
            check_all();
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        phase = "R1";
        check_all();                       // state under reset
        rst_n = 1'b1;
        check_all();
        step(40);

        // R2 / R4 / R8: every digit count, including an out-of-range code
        for (int m = 0; m <= 10; m++) begin
            phase = "R2";
            mode_i = (m == 10) ? 4'd15 : 4'(m);
            dim_i = 3'(m % 8 == 0 ? 7 : m % 8);
            mask_a = 16'h1 << m ^ 16'hA005;
            mask_b = 16'h8000 >> m ^ 16'h0C30;
            step(2 * 13 * 16 + 32);
        end

        // R5: all dimming steps at four digits
        phase = "R5";
        mode_i = 4'd0;
        for (int d = 0; d < 8; d++) begin
            dim_i = 3'(d);
            step(5 * 16 * 2);
        end

        // R6: display off, keys still scanned
        phase = "R6";
        mode_i = 4'd3; dim_i = 3'd7; disp_on_i = 1'b0;
        mask_a = 16'h5A5A; mask_b = 16'h0FF0;
        step(320);
        disp_on_i = 1'b1;

        // R9: change mode in mid cycle
        phase = "R9";
        mode_i = 4'd8;
        step(250);
        mode_i = 4'd1;
        step(20);
        mode_i = 4'd6;
        step(500);

        // R11: ticks held low
        phase = "R11";
        tick_i = 1'b0;
        step(40);
        tick_i = 1'b1;
        step(60);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule